// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic/logic unit for a 32-bit datapath. It is built from a row of identical one-bit cells. Each cell forms the AND, the OR and the full-adder sum of its operand bits. It then picks one of those, or a fed-in "less" bit, as its result. The carry ripples from each cell to the next. A 3-bit operation select chooses bitwise AND, bitwise OR, add, subtract or signed set-on-less-than.

Subtraction reuses the adder. The top select bit inverts operand B at every cell and also supplies the carry into the lowest cell, so the chain computes A + ~B + 1. For set-on-less-than, the sign of that difference is taken at the top cell and corrected for overflow. It is then routed back into the "less" input of the lowest cell, while every other cell's "less" input is held at zero.

Two flags come with each result. A zero flag supports equality tests by subtraction. A signed-overflow flag is raised only for add and subtract.

Top module: `salu_top`

## Requirements
- R1: Select 000 gives the bitwise AND of A and B.
- R2: Select 001 gives the bitwise OR of A and B.
- R3: Select 010 gives A + B modulo 2^32. A carry out of bit 31 is dropped.
- R4: Select 110 gives A - B modulo 2^32.
- R5: Select 111 gives 1 when A < B as signed two's-complement values and 0 otherwise. Result bits 31..1 are always 0.
- R6: The set-on-less-than answer stays correct when A - B overflows, for example 0x80000000 < 0x00000001 gives 1 and 0x7FFFFFFF < 0xFFFFFFFF gives 0.
- R7: The zero flag is 1 exactly when all 32 result bits are 0. This includes equal operands under subtract.
- R8: Under add, overflow is 1 when A and B have equal sign bits and the result's sign bit differs from them, and 0 otherwise.
- R9: Under subtract, overflow is 1 when A and B have different sign bits and the result's sign bit differs from A's, and 0 otherwise.
- R10: Under AND, OR and set-on-less-than, the overflow flag is 0.
- R11: The unused selects 011, 100 and 101 give result 0, zero flag 1 and overflow 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation select (000 AND, 001 OR, 010 add, 110 subtract, 111 set-on-less-than) |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest case to reach is set-on-less-than while the internal subtraction overflows. In that case the raw sign of A - B gives the wrong answer, and only the overflow correction on the fed-back bit gives the right one. The stimulus reaches it by choosing operand pairs at opposite ends of the signed range, such as the most negative value against 1 and the most positive value against -1. Overflow on add and subtract is driven the same way, with sign-boundary pairs including a sum that wraps to exactly zero. That pair checks the zero and overflow flags together.

// File: rtl/salu_pkg.sv
package salu_pkg;

    localparam int unsigned SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_AND = 3'b000;
    localparam logic [SEL_W-1:0] SEL_OR  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_ADD = 3'b010;
    localparam logic [SEL_W-1:0] SEL_SUB = 3'b110;
    localparam logic [SEL_W-1:0] SEL_SLT = 3'b111;

    // Cell multiplexer codes, taken from the low select bits.
    localparam logic [1:0] PICK_AND  = 2'b00;
    localparam logic [1:0] PICK_OR   = 2'b01;
    localparam logic [1:0] PICK_SUM  = 2'b10;
    localparam logic [1:0] PICK_LESS = 2'b11;

    function automatic logic sel_is_legal(input logic [SEL_W-1:0] s);
        return (s == SEL_AND) || (s == SEL_OR) || (s == SEL_ADD) ||
               (s == SEL_SUB) || (s == SEL_SLT);
    endfunction

    function automatic logic sel_is_arith(input logic [SEL_W-1:0] s);
        return (s == SEL_ADD) || (s == SEL_SUB);
    endfunction

endpackage

// File: rtl/salu_cell.sv
module salu_cell
    import salu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       b_flip_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  logic [1:0] pick_i,
    output logic       sum_o,
    output logic       cout_o,
    output logic       res_o
);

    logic b_eff_d;

    // Separate statements keep the carry path independent of less_i.
    assign b_eff_d = b_i ^ b_flip_i;
    assign sum_o   = a_i ^ b_eff_d ^ cin_i;
    assign cout_o  = (a_i & b_eff_d) | (a_i & cin_i) | (b_eff_d & cin_i);

    always_comb begin
        unique case (pick_i)
            PICK_AND: res_o = a_i & b_eff_d;
            PICK_OR:  res_o = a_i | b_eff_d;
            PICK_SUM: res_o = sum_o;
            default:  res_o = less_i;
        endcase
    end

endmodule

// File: rtl/salu_chain.sv
module salu_chain #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             b_flip_i,
    input  logic [1:0]       pick_i,
    input  logic             less_lsb_i,
    output logic [WIDTH-1:0] res_o,
    output logic             sum_msb_o,
    output logic             c_into_msb_o,
    output logic             c_out_o
);

    localparam int unsigned MSB = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic cin_d;
        logic less_d;
        logic sum_d;
        logic cout_d;
        logic res_d;

        if (i == 0) begin : g_first
            assign cin_d  = b_flip_i;
            assign less_d = less_lsb_i;
        end else begin : g_rest
            assign cin_d  = g_lane[i-1].cout_d;
            assign less_d = 1'b0;
        end

        salu_cell u_cell (
            .a_i      (a_i[i]),
            .b_i      (b_i[i]),
            .b_flip_i (b_flip_i),
            .cin_i    (cin_d),
            .less_i   (less_d),
            .pick_i   (pick_i),
            .sum_o    (sum_d),
            .cout_o   (cout_d),
            .res_o    (res_d)
        );

        assign res_o[i] = res_d;
    end

    assign sum_msb_o    = g_lane[MSB].sum_d;
    assign c_into_msb_o = g_lane[MSB].cin_d;
    assign c_out_o      = g_lane[MSB].cout_d;

endmodule

// File: rtl/salu_flags.sv
module salu_flags #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             sum_msb_i,
    input  logic             c_into_msb_i,
    input  logic             c_out_i,
    input  logic             arith_i,
    output logic             set_o,
    output logic             zero_o,
    output logic             ovf_o
);

    logic raw_ovf_d;

    // Overflow from the carries around the top cell.
    assign raw_ovf_d = c_into_msb_i ^ c_out_i;
    // The sign of the difference, corrected when the difference overflowed.
    assign set_o     = sum_msb_i ^ raw_ovf_d;
    assign ovf_o     = arith_i & raw_ovf_d;
    assign zero_o    = ~(|res_i);

endmodule

// File: rtl/salu_top.sv
module salu_top
    import salu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);

    localparam int unsigned MSB = WIDTH - 1;

    logic             legal_d;
    logic             arith_d;
    logic             set_d;
    logic             sum_msb_d;
    logic             c_into_msb_d;
    logic             c_out_d;
    logic [WIDTH-1:0] raw_res_d;

    assign legal_d = sel_is_legal(op_sel);
    assign arith_d = sel_is_arith(op_sel);

    salu_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i          (op_a),
        .b_i          (op_b),
        .b_flip_i     (op_sel[2]),
        .pick_i       (op_sel[1:0]),
        .less_lsb_i   (set_d),
        .res_o        (raw_res_d),
        .sum_msb_o    (sum_msb_d),
        .c_into_msb_o (c_into_msb_d),
        .c_out_o      (c_out_d)
    );

    assign result = legal_d ? raw_res_d : '0;

    salu_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i        (result),
        .sum_msb_i    (sum_msb_d),
        .c_into_msb_i (c_into_msb_d),
        .c_out_i      (c_out_d),
        .arith_i      (arith_d),
        .set_o        (set_d),
        .zero_o       (zero_flag),
        .ovf_o        (ovf_flag)
    );

    // The slice chain is checked against native operators.
    always_comb begin
        if (op_sel == SEL_AND)
            a_r1_and_bits: assert (result == (op_a & op_b));
        if (op_sel == SEL_ADD)
            a_r3_add_sum: assert (result == op_a + op_b);
        if (op_sel == SEL_SUB)
            a_r4_sub_diff: assert (result == op_a - op_b);
        if (op_sel == SEL_SLT) begin
            a_r5_slt_upper_clear: assert (result[MSB:1] == '0);
            a_r6_slt_signed: assert (result[0] == ($signed(op_a) < $signed(op_b)));
        end
        if (op_sel == SEL_ADD)
            a_r8_add_overflow: assert (ovf_flag ==
                ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])));
        if (op_sel == SEL_SUB)
            a_r9_sub_overflow: assert (ovf_flag ==
                ((op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB])));
        if (!sel_is_arith(op_sel))
            a_r10_no_overflow: assert (!ovf_flag);
    end

endmodule

// File: tb/sim_salu_top.sv
module sim_salu_top;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [2:0]   op_sel = 3'b000;
    logic [W-1:0] result;
    logic         zero_flag;
    logic         ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    salu_top #(.WIDTH(W)) u0 (
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sel    (op_sel),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    // Expected values taken from the requirement text.
    function automatic logic [W-1:0] ref_res(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [2:0] s);
        case (s)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b110:  return a - b;
            3'b111:  return {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: return '0;
        endcase
    endfunction

    function automatic logic ref_ovf(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic [2:0] s);
        logic [W-1:0] r;
        r = ref_res(a, b, s);
        if (s == 3'b010) return (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
        if (s == 3'b110) return (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        return 1'b0;
    endfunction

    task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2:0] s);
        logic [W-1:0] er;
        logic         ez;
        logic         eo;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = s;
        #1;
        er = ref_res(a, b, s);
        ez = (er == '0);
        eo = ref_ovf(a, b, s);
        checks++;
        if (result !== er || zero_flag !== ez || ovf_flag !== eo) begin
            errors++;
            $display("FAIL %s: a=%h b=%h sel=%b got res=%h z=%b v=%b exp res=%h z=%b v=%b",
                     tag, a, b, s, result, zero_flag, ovf_flag, er, ez, eo);
        end
    endtask

    task automatic t_reset_state;
        apply("R7 idle", '0, '0, 3'b000);
    endtask

    task automatic t_logic;
        apply("R1 and", 32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000);
        apply("R1 and", 32'hAAAA_AAAA, 32'h5555_5555, 3'b000);
        apply("R2 or",  32'hAAAA_0000, 32'h5555_000F, 3'b001);
        apply("R2 or",  32'h0000_0000, 32'h0000_0000, 3'b001);
        apply("R10 logic no ovf", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b001);
    endtask

    task automatic t_add;
        apply("R3 add", 32'd7, 32'd6, 3'b010);
        apply("R3 add wrap", 32'hFFFF_FFFF, 32'd1, 3'b010);
        apply("R8 add pos ovf", 32'h7FFF_FFFF, 32'd1, 3'b010);
        apply("R8 add neg ovf", 32'h8000_0000, 32'h8000_0000, 3'b010);
        apply("R8 add mixed", 32'h8000_0000, 32'h7FFF_FFFF, 3'b010);
    endtask

    task automatic t_sub;
        apply("R4 sub", 32'd7, 32'd6, 3'b110);
        apply("R7 sub equal", 32'h1234_5678, 32'h1234_5678, 3'b110);
        apply("R9 sub neg-pos", 32'h8000_0000, 32'd1, 3'b110);
        apply("R9 sub pos-neg", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
        apply("R9 sub same sign", 32'hFFFF_FFF0, 32'hFFFF_FFFF, 3'b110);
    endtask

    task automatic t_slt;
        apply("R5 slt neg<0", 32'hFFFF_FFFF, 32'd0, 3'b111);
        apply("R5 slt equal", 32'd42, 32'd42, 3'b111);
        apply("R5 slt greater", 32'd43, 32'd42, 3'b111);
        apply("R5 slt less", 32'd3, 32'd9, 3'b111);
        apply("R6 slt min<1", 32'h8000_0000, 32'd1, 3'b111);
        apply("R6 slt max<-1", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    endtask

    task automatic t_unused;
        apply("R11 sel011", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
        apply("R11 sel100", 32'hFFFF_FFFF, 32'h0000_0000, 3'b100);
        apply("R11 sel101", 32'h8000_0000, 32'h7FFF_FFFF, 3'b101);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_logic();
        t_add();
        t_sub();
        t_slt();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule